// File: doc/BRIEF.md
# Indirect Message-Bus Register Bridge

This block gives a host that only sees a 32-bit configuration register space indirect access to registers held inside an internal unit. The host never addresses the target registers directly. It writes a packed control word, which carries an opcode, a port number, a register offset and a byte-lane mask. That one write starts a single transaction on the internal side. A separate 32-bit data register carries the value in both directions. For a write the host loads the data register first, and the control word then commits it. For a read the host issues the control word first, and the data register holds the fetched value once the transaction has finished.

The bridge contains the control-word decode, a small target register file that answers on one local port, a transaction sequencer with a fixed latency, and a sticky error flag. The flag records commands the bridge refused. The host polls a busy bit in a status register to find out when a transaction has finished. A one-cycle done strobe marks the final cycle.

Top module: `mbb_bridge`

## Requirements
- R1: After reset the busy flag, the error flag, the data register and every target register read as zero.
- R2: A control write to config offset 0xD0 decodes its fields as follows: opcode in bits [31:24], port in [23:16], target offset in [15:8], byte enables in [7:4]. Bits [3:0] are ignored. Opcode 0xD0 on port 0x03 reads the target register into the data register at config offset 0xD4 when the transaction completes. The data register keeps its old value while the transaction is still busy.
- R3: Opcode 0xE0 on port 0x03 commits the current data register contents into the addressed target register when the transaction completes. The host must load the data register before it writes the control word.
- R4: Byte-enable bit 4+k gates byte lane k (bits 8k+7:8k) of a write. A partial mask changes only the enabled bytes.
- R5: Busy rises on the clock edge that accepts a valid control write and stays high for exactly LATENCY cycles (default 3). The done output is high only in the last busy cycle.
- R6: A control write that arrives while busy is dropped. It changes no target register and does not extend busy.
- R7: A write to the data register while busy is ignored. The pending write commits the value that was loaded before the control write.
- R8: A control write with an opcode other than 0xD0/0xE0, or with a port other than 0x03, does not start a transaction. It leaves the data register unchanged and sets a sticky error flag in bit 0 of the status register at config offset 0xD8. Only reset clears the flag.
- R9: Target offsets outside 0x10..0x15 on port 0x03 read as zero, and writes to them are discarded.
- R10: Bit 1 of the status register mirrors busy. A config read of any offset other than 0xD0, 0xD4 and 0xD8 returns zero. Offset 0xD0 reads back the last accepted valid control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Config write strobe, one cycle per write |
| cfg_addr | input | 8 | Config register offset |
| cfg_wdata | input | 32 | Config write data |
| cfg_rdata | output | 32 | Config read data for cfg_addr (combinational) |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Last cycle of a transaction |

## Verification
The hardest situations to reach are the ones that overlap an open transaction. These are a second control word, or a fresh data-register load, arriving between acceptance and completion. The bench issues those writes on the negative edges right after the accepting edge, while busy is known to be high. It then reads the target back to prove that the pending commit used the earlier data and that the dropped command left no trace. Refused commands are checked the same way: the bench loads a known data value, sends a bad opcode or port, and reads the data register and status back at once.

// File: rtl/mbb_pkg.sv
// Package: shared encodings and field layout for the message-bus bridge.
// Assumes a 32-bit control word with fixed field positions.
package mbb_pkg;
    localparam logic [7:0] OP_READ  = 8'hD0;
    localparam logic [7:0] OP_WRITE = 8'hE0;

    localparam logic [7:0] CFG_CTL  = 8'hD0;
    localparam logic [7:0] CFG_DATA = 8'hD4;
    localparam logic [7:0] CFG_STAT = 8'hD8;

    typedef struct packed {
        logic [7:0] opcode;
        logic [7:0] port;
        logic [7:0] offset;
        logic [3:0] lanes;
        logic [3:0] unused;
    } ctl_word_t;
endpackage

// File: rtl/mbb_decode.sv
// Module: splits a control word into fields and classifies it.
// Assumes the packed layout in mbb_pkg; the unused nibble is ignored.
module mbb_decode
    import mbb_pkg::*;
#(
    parameter logic [7:0] LOCAL_PORT = 8'h03
) (
    input  logic [31:0] word,
    output logic        is_write,
    output logic        valid,
    output logic [7:0]  offset,
    output logic [3:0]  lanes
);
    ctl_word_t f;

    // Field split and opcode/port validation.
    always_comb begin
        f        = ctl_word_t'(word);
        offset   = f.offset;
        lanes    = f.lanes;
        is_write = (f.opcode == OP_WRITE);
        valid    = ((f.opcode == OP_READ) || (f.opcode == OP_WRITE))
                   && (f.port == LOCAL_PORT);
    end
endmodule

// File: rtl/mbb_regfile.sv
// Module: target register file on the local port, byte-lane write enables.
// Assumes offsets BASE..BASE+NUM_REGS-1 are implemented; others read zero.
module mbb_regfile #(
    parameter int         DATA_W   = 32,
    parameter int         NUM_REGS = 6,
    parameter logic [7:0] BASE     = 8'h10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [7:0]          addr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [DATA_W/8-1:0] wlanes,
    output logic [DATA_W-1:0]   rdata
);
    localparam int LANES = DATA_W / 8;

    logic [DATA_W-1:0] regs [NUM_REGS];
    logic              hit;
    logic [7:0]        idx;

    // Offset-to-index translation and range check.
    always_comb begin
        idx = addr - BASE;
        hit = (addr >= BASE) && (idx < 8'(NUM_REGS));
    end

    generate
        for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
            for (genvar b = 0; b < LANES; b++) begin : g_lane
                // One byte lane of one register, gated by its enable bit.
                always_ff @(posedge clk) begin
                    if (!rst_n)
                        regs[r][8*b +: 8] <= '0;
                    else if (we && hit && (idx == 8'(r)) && wlanes[b])
                        regs[r][8*b +: 8] <= wdata[8*b +: 8];
                end
            end
        end
    endgenerate

    // Read mux: zero for unimplemented offsets.
    always_comb begin
        rdata = '0;
        for (int r = 0; r < NUM_REGS; r++)
            if (hit && (idx == 8'(r))) rdata = regs[r];
    end

    assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (addr < BASE || addr >= BASE + 8'(NUM_REGS)) |-> (rdata == '0));
endmodule

// File: rtl/mbb_sequencer.sv
// Module: holds busy for a fixed number of cycles per accepted transaction.
// Assumes start only pulses when idle.
module mbb_sequencer #(
    parameter int LATENCY = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(LATENCY + 1);

    logic [CW-1:0] cnt;

    // Completion is the last busy cycle.
    always_comb done = busy && (cnt == CW'(1));

    // Countdown of the remaining busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start && !busy) begin
            busy <= 1'b1;
            cnt  <= CW'(LATENCY);
        end else if (busy) begin
            cnt  <= cnt - CW'(1);
            if (done) busy <= 1'b0;
        end
    end

    assert_done_in_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
    assert_busy_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
    assert_done_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
endmodule

// File: rtl/mbb_bridge.sv
// Module: top of the indirect register bridge. It holds the control and data
// config registers and a sticky error flag, and drives the target register file.
// Assumes one cfg write per cycle at most; reads are combinational.
module mbb_bridge
    import mbb_pkg::*;
#(
    parameter int         NUM_REGS   = 6,
    parameter logic [7:0] BASE       = 8'h10,
    parameter logic [7:0] LOCAL_PORT = 8'h03,
    parameter int         LATENCY    = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr,
    input  logic [7:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    output logic        busy,
    output logic        done
);
    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;

    logic              dec_wr, dec_valid;
    logic [7:0]        dec_off;
    logic [LANES-1:0]  dec_lanes;
    logic              ctl_take, data_take, start;
    logic [DATA_W-1:0] ctl_q, data_q, rf_rdata;
    logic              op_wr_q, err_q;
    logic [7:0]        off_q;
    logic [LANES-1:0]  lanes_q;

    mbb_decode #(.LOCAL_PORT(LOCAL_PORT)) u_dec (
        .word(cfg_wdata), .is_write(dec_wr), .valid(dec_valid),
        .offset(dec_off), .lanes(dec_lanes)
    );

    // Host write qualification: nothing is taken while busy.
    always_comb begin
        ctl_take  = cfg_wr && (cfg_addr == CFG_CTL) && !busy;
        data_take = cfg_wr && (cfg_addr == CFG_DATA) && !busy;
        start     = ctl_take && dec_valid;
    end

    mbb_sequencer #(.LATENCY(LATENCY)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done)
    );

    mbb_regfile #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .BASE(BASE)) u_rf (
        .clk(clk), .rst_n(rst_n), .we(done && op_wr_q), .addr(off_q),
        .wdata(data_q), .wlanes(lanes_q), .rdata(rf_rdata)
    );

    // Latch the fields of an accepted valid command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q   <= '0;
            op_wr_q <= 1'b0;
            off_q   <= '0;
            lanes_q <= '0;
        end else if (start) begin
            ctl_q   <= cfg_wdata;
            op_wr_q <= dec_wr;
            off_q   <= dec_off;
            lanes_q <= dec_lanes;
        end
    end

    // Data register: host load when idle, read result on completion.
    always_ff @(posedge clk) begin
        if (!rst_n)
            data_q <= '0;
        else if (data_take)
            data_q <= cfg_wdata;
        else if (done && !op_wr_q)
            data_q <= rf_rdata;
    end

    // Sticky error for refused commands.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else if (ctl_take && !dec_valid)
            err_q <= 1'b1;
    end

    // Config read mux.
    always_comb begin
        case (cfg_addr)
            CFG_CTL:  cfg_rdata = ctl_q;
            CFG_DATA: cfg_rdata = data_q;
            CFG_STAT: cfg_rdata = {30'd0, busy, err_q};
            default:  cfg_rdata = '0;
        endcase
    end

    assert_bad_cmd_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_take && !dec_valid) |=> (!busy && err_q));
    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);
    assert_data_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_take && !done) |=> $stable(data_q));
    assert_busy_no_extend_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cfg_wr && cfg_addr == CFG_CTL) |=> $stable(off_q));
endmodule

// File: tb/tb_mbb_bridge.sv
module tb_mbb_bridge;
    localparam int CLK_PERIOD = 10;
    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        busy, done;

    int checks = 0;
    int fails = 0;

    mbb_bridge #(.LATENCY(LAT)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .busy(busy), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] cw(input logic [7:0] op, input logic [7:0] port,
                                       input logic [7:0] off, input logic [3:0] be);
        return {op, port, off, be, 4'h0};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; cfg_wr = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        cfg_addr = a; #1; d = cfg_rdata;
    endtask

    // Count busy cycles from the negedge after acceptance until idle.
    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 50) begin n++; @(negedge clk); end
    endtask

    task automatic target_write(input logic [7:0] off, input logic [31:0] d, input logic [3:0] be);
        int n;
        wr(8'hD4, d);
        wr(8'hD0, cw(8'hE0, 8'h03, off, be));
        wait_idle(n);
    endtask

    task automatic target_read(input logic [7:0] off, output logic [31:0] d);
        int n;
        wr(8'hD0, cw(8'hD0, 8'h03, off, 4'hF));
        wait_idle(n);
        rd(8'hD4, d);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        rd(8'hD8, v); check("R1 status", v, 0);
        rd(8'hD4, v); check("R1 data", v, 0);
        check("R1 busy", {31'd0, busy}, 0);
        target_read(8'h12, v); check("R1 target", v, 0);
    endtask

    task automatic t_write_read();
        logic [31:0] v;
        int n;
        target_write(8'h11, 32'hA5B6C7D8, 4'hF);
        target_write(8'h14, 32'h01020304, 4'hF);
        wr(8'hD4, 32'h55555555);
        wr(8'hD0, cw(8'hD0, 8'h03, 8'h11, 4'hF) | 32'h0000000F);
        rd(8'hD4, v); check("R2 data held while busy", v, 32'h55555555);
        wait_idle(n);
        rd(8'hD4, v); check("R2 read result", v, 32'hA5B6C7D8);
        rd(8'hD0, v); check("R10 ctl readback", v, cw(8'hD0, 8'h03, 8'h11, 4'hF) | 32'h0000000F);
        target_read(8'h14, v); check("R3 write commit", v, 32'h01020304);
    endtask

    task automatic t_lanes();
        logic [31:0] v;
        target_write(8'h10, 32'h11223344, 4'hF);
        target_write(8'h10, 32'hAABBCCDD, 4'b0101);
        target_read(8'h10, v); check("R4 lanes 0101", v, 32'h11BB33DD);
        target_write(8'h10, 32'hEEFF0000, 4'b1000);
        target_read(8'h10, v); check("R4 lane 3", v, 32'hEEBB33DD);
    endtask

    task automatic t_busy_len();
        int n;
        int dn = 0;
        wr(8'hD0, cw(8'hD0, 8'h03, 8'h10, 4'hF));
        n = 0;
        while (busy && n < 50) begin dn += int'(done); n++; @(negedge clk); end
        check("R5 busy cycles", n, LAT);
        check("R5 done count", dn, 1);
    endtask

    task automatic t_overlap();
        logic [31:0] v;
        int n;
        target_write(8'h13, 32'h0, 4'hF);
        wr(8'hD4, 32'hCAFE0001);
        wr(8'hD0, cw(8'hE0, 8'h03, 8'h12, 4'hF));
        n = 1;
        wr(8'hD0, cw(8'hE0, 8'h03, 8'h13, 4'hF));  // R6 dropped
        n++;
        while (busy && n < 50) begin n++; @(negedge clk); end
        check("R6 busy not extended", n, LAT);
        target_read(8'h13, v); check("R6 dropped write", v, 0);
        wr(8'hD4, 32'h12345678);
        wr(8'hD0, cw(8'hE0, 8'h03, 8'h12, 4'hF));
        wr(8'hD4, 32'hDEADBEEF);                   // R7 ignored
        wait_idle(n);
        rd(8'hD4, v); check("R7 data reg unchanged", v, 32'h12345678);
        target_read(8'h12, v); check("R7 committed value", v, 32'h12345678);
    endtask

    task automatic t_errors();
        logic [31:0] v;
        do_reset();
        wr(8'hD4, 32'h0BADF00D);
        wr(8'hD0, cw(8'hC0, 8'h03, 8'h10, 4'hF));
        check("R8 no busy on bad opcode", {31'd0, busy}, 0);
        rd(8'hD8, v); check("R8 error bit", v, 32'h1);
        rd(8'hD4, v); check("R8 data unchanged", v, 32'h0BADF00D);
        wr(8'hD0, cw(8'hE0, 8'h04, 8'h10, 4'hF));
        target_read(8'h10, v); check("R8 bad port no write", v, 0);
        rd(8'hD8, v); check("R8 sticky", v, 32'h1);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        target_write(8'h20, 32'hFFFFFFFF, 4'hF);
        target_read(8'h20, v); check("R9 unmapped reads zero", v, 0);
        target_read(8'h0F, v); check("R9 below base zero", v, 0);
        rd(8'h40, v); check("R10 unmapped cfg", v, 0);
        wr(8'hD0, cw(8'hD0, 8'h03, 8'h10, 4'hF));
        rd(8'hD8, v); check("R10 busy bit", v & 32'h2, 32'h2);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_write_read();
        t_lanes();
        t_busy_len();
        t_overlap();
        t_unmapped();
        t_errors();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule